// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the lowest layer of an I2C master. It moves one bit per command across the bus. The command is one of three kinds: drive a bit, read a bit, or check an acknowledge. The block drives both bus wires through open-drain enables: a 1 lets the line float high and a 0 pulls it low. It reads both wires back through a two-flop synchronizer. Each bit is one released (high) clock phase followed by one driven-low clock phase, and each phase lasts one half-period.

The half-period is in microseconds. It is worked out from a bus frequency in kHz and an I/O latency allowance. A prescaler divides the system clock down to a microsecond tick. A target device may hold SCL low to stretch the clock. Because of this, the high phase is only counted once SCL has been read back high. A stretch that lasts longer than a programmable limit ends the command with a timeout code. While waiting for SCL, the block checks the line on every clock for a short window, then only at a slower poll interval.

The controller above this block is responsible for byte framing, start and stop conditions, and the register interface. Between commands the block keeps SCL pulled low, so the bus stays reserved.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is applied and after it is released, `scl_oe` and `sda_oe` are 1 (both lines released), `cmd_ready` is 1 and `rsp_done` is 0.
- R2: The half-period H in microseconds is max(floor(500 / F) - L, 1), where F is `cfg_bus_khz` (a value of 0 is treated as 1) and L is `cfg_io_lat_us`. The block captures H when it accepts a command. `rsp_done` rises exactly H * CLK_PER_US clock cycles after `scl_oe` falls at the end of the high phase.
- R3: `sda_oe` takes its value for the bit at least one cycle before `scl_oe` is released. `sda_oe` does not change while the high phase runs.
- R4: The high phase starts counting only once the synchronized SCL reads high. `scl_oe` stays released for exactly H * CLK_PER_US + 3 cycles after the SCL line rises: 2 cycles of synchronizer plus 1 decision cycle.
- R5: If SCL is still read low when the stretch limit T (`cfg_stretch_to_us`) is reached, the command ends with `rsp_err` = 2'b01. `scl_oe` and `sda_oe` are both left at 1. Inside the fast window, `rsp_done` rises T * CLK_PER_US + 1 cycles after `scl_oe` rose.
- R6: For the first FAST_US microseconds of the wait, SCL is checked on every clock. After that it is checked only at poll instants FAST_US + k * SLOW_US microseconds after `scl_oe` rose. A stretch released between two polls is seen at the next poll, and a limit that falls between polls is reported at the next poll.
- R7: A send command (op 2'b00) holds `sda_oe` at `cmd_bit` for the whole bit. It returns `rsp_bit` = `cmd_bit` and `rsp_err` = 2'b00.
- R8: A receive command (op 2'b01, and op 2'b11 which behaves the same way) releases SDA. It samples the line once, ceil(H/2) microseconds into the high phase, and returns that value in `rsp_bit` with `rsp_err` = 2'b00.
- R9: An acknowledge command (op 2'b10) releases SDA. It samples SDA when the high phase begins and then on every microsecond tick of that phase. Any low reading gives `rsp_bit` = 0 and `rsp_err` = 2'b00; otherwise the result is `rsp_bit` = 1 and `rsp_err` = 2'b10. The high phase is never cut short.
- R10: `cmd_ready` is 1 only while idle. A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. Each accepted command produces exactly one single-cycle `rsp_done` pulse.
- R11: After a command completes without a timeout, `scl_oe` stays 0 until the next command releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus_khz | input | FREQ_W | Bus frequency in kHz |
| cfg_io_lat_us | input | LAT_W | I/O latency allowance in microseconds |
| cfg_stretch_to_us | input | TO_W | SCL low limit in microseconds |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 00 send, 01 receive, 10 acknowledge check, 11 receive |
| cmd_bit | input | 1 | Bit value for a send |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_bit | output | 1 | Result bit |
| rsp_err | output | 2 | 00 none, 01 SCL timeout, 10 no acknowledge |
| scl_in | input | 1 | SCL line readback |
| sda_in | input | 1 | SDA line readback |
| scl_oe | output | 1 | SCL open-drain enable, 1 releases |
| sda_oe | output | 1 | SDA open-drain enable, 1 releases |

## Verification
Every timing result is counted from an event on the bus, never from the command, so each check can give an exact cycle count. The completion pulse is due H * CLK_PER_US cycles after SCL is pulled low. The pull-low is due H * CLK_PER_US + 3 cycles after the line reads high. A fast-window timeout completes T * CLK_PER_US + 1 cycles after release, and a slow-window event lands on a multiple of the poll interval. The bench timestamps each edge on the falling clock, while its stimulus changes 2 ns after the rising edge. The line windows it drives for the receive and acknowledge tests are placed relative to the computed start of the high phase. This places each pulse so that it hits, or misses, a specific sample tick.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [1:0] {
    OP_SEND = 2'b00,
    OP_RECV = 2'b01,
    OP_ACK  = 2'b10,
    OP_RSVD = 2'b11
  } bit_op_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'b00,
    ERR_TIMEOUT = 2'b01,
    ERR_NACK    = 2'b10
  } bit_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_HIGH,
    ST_LOW
  } eng_state_e;

endpackage

// File: rtl/i2c_bit_sync.sv
module i2c_bit_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        stab_q <= 1'b1;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end

    assign q[i] = stab_q;
  end

endmodule

// File: rtl/i2c_bit_usec.sv
module i2c_bit_usec #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  if (CLK_PER_US <= 1) begin : g_direct
    assign tick = 1'b1;
  end else begin : g_count
    localparam int CW = $clog2(CLK_PER_US);
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
      if (clr || (cnt_q == LAST)) cnt_d = '0;
      else                        cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2
  end

endmodule

// File: rtl/i2c_bit_halfper.sv
module i2c_bit_halfper #(
  parameter int FREQ_W = 10,
  parameter int LAT_W  = 8,
  parameter int HP_W   = 10
) (
  input  logic [FREQ_W-1:0] bus_khz,
  input  logic [LAT_W-1:0]  lat_us,
  output logic [HP_W-1:0]   half_us
);

  // 1e6 / (2 * f_Hz) in microseconds equals 500 / f_kHz
  localparam logic [31:0] NUM    = 32'd500;
  localparam logic [31:0] HP_MAX = 32'((64'd1 << HP_W) - 64'd1);

  logic [31:0] divisor;
  logic [31:0] quot;
  logic [31:0] trimmed;
  logic [31:0] clipped;

  always_comb begin
    divisor = (bus_khz == '0) ? 32'd1 : 32'(bus_khz);
    quot    = NUM / divisor;
    trimmed = (quot > 32'(lat_us)) ? (quot - 32'(lat_us)) : 32'd0;
    if (trimmed == 32'd0)      clipped = 32'd1;
    else if (trimmed > HP_MAX) clipped = HP_MAX;
    else                       clipped = trimmed;
    half_us = HP_W'(clipped);
  end

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int FAST_US    = 1000,
  parameter int SLOW_US    = 1000,
  parameter int FREQ_W     = 10,
  parameter int LAT_W      = 8,
  parameter int TO_W       = 20,
  parameter int HP_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] cfg_bus_khz,
  input  logic [LAT_W-1:0]  cfg_io_lat_us,
  input  logic [TO_W-1:0]   cfg_stretch_to_us,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_bit,
  output logic              rsp_done,
  output logic              rsp_bit,
  output logic [1:0]        rsp_err,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);

  localparam int PC_W = (SLOW_US > 1) ? $clog2(SLOW_US) : 1;
  localparam logic [PC_W-1:0] SLOW_LAST = PC_W'(SLOW_US - 1);
  localparam logic [TO_W-1:0] FAST_V    = TO_W'(FAST_US);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_i    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_i    <= rst_meta_q;
    end
  end

  // line synchronizers, microsecond tick, half-period
  logic [1:0] lines_s;
  logic       scl_s;
  logic       sda_s;

  i2c_bit_sync #(.N(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({sda_in, scl_in}),
    .q     (lines_s)
  );

  assign scl_s = lines_s[0];
  assign sda_s = lines_s[1];

  logic tclr;
  logic us_tick;

  i2c_bit_usec #(.CLK_PER_US(CLK_PER_US)) u_usec (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (tclr),
    .tick  (us_tick)
  );

  logic [HP_W-1:0] half_calc;

  i2c_bit_halfper #(.FREQ_W(FREQ_W), .LAT_W(LAT_W), .HP_W(HP_W)) u_half (
    .bus_khz (cfg_bus_khz),
    .lat_us  (cfg_io_lat_us),
    .half_us (half_calc)
  );

  // state
  eng_state_e      state_q, state_d;
  bit_op_e         op_q;
  logic            bit_q;
  logic [HP_W-1:0] half_q;
  logic [TO_W-1:0] to_q;
  logic            scl_oe_q, scl_oe_d;
  logic            sda_oe_q, sda_oe_d;
  logic [HP_W-1:0] ph_q, ph_d;
  logic [TO_W-1:0] wait_q, wait_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            samp_q, samp_d;
  logic            done_q, done_d;
  logic            rbit_q, rbit_d;
  bit_err_e        err_q, err_d;

  logic            accept;
  logic            is_recv;
  logic            in_fast;
  logic            poll_now;
  logic            ph_last;
  logic            go_high;
  logic            go_timeout;
  logic [TO_W:0]   wait_inc;
  logic [HP_W:0]   ph_inc;
  logic [HP_W:0]   mid_us;

  assign accept   = cmd_valid && (state_q == ST_IDLE);
  assign is_recv  = (op_q == OP_RECV) || (op_q == OP_RSVD);
  assign in_fast  = (wait_q < FAST_V);
  assign poll_now = us_tick && (pc_q == SLOW_LAST);
  assign ph_last  = (ph_q == (half_q - HP_W'(1)));
  assign wait_inc = {1'b0, wait_q} + (TO_W+1)'(1);
  assign ph_inc   = {1'b0, ph_q} + (HP_W+1)'(1);
  assign mid_us   = ({1'b0, half_q} + (HP_W+1)'(1)) >> 1;

  // next-state process
  always_comb begin
    state_d    = state_q;
    scl_oe_d   = scl_oe_q;
    sda_oe_d   = sda_oe_q;
    ph_d       = ph_q;
    wait_d     = wait_q;
    pc_d       = pc_q;
    samp_d     = samp_q;
    done_d     = 1'b0;
    rbit_d     = rbit_q;
    err_d      = err_q;
    tclr       = 1'b0;
    go_high    = 1'b0;
    go_timeout = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          sda_oe_d = (bit_op_e'(cmd_op) == OP_SEND) ? cmd_bit : 1'b1;
          samp_d   = 1'b1;
          state_d  = ST_SETUP;
        end
      end

      ST_SETUP: begin
        scl_oe_d = 1'b1;
        wait_d   = '0;
        pc_d     = '0;
        tclr     = 1'b1;
        state_d  = ST_WAIT;
      end

      ST_WAIT: begin
        if (us_tick && (wait_q != '1)) wait_d = wait_q + TO_W'(1);
        if (in_fast) begin
          if (scl_s)                go_high    = 1'b1;
          else if (wait_q >= to_q)  go_timeout = 1'b1;
        end else if (us_tick) begin
          pc_d = poll_now ? '0 : (pc_q + PC_W'(1));
          if (poll_now) begin
            if (scl_s)                           go_high    = 1'b1;
            else if (wait_inc >= {1'b0, to_q})   go_timeout = 1'b1;
          end
        end
        if (go_high) begin
          state_d = ST_HIGH;
          ph_d    = '0;
          tclr    = 1'b1;
          if (op_q == OP_ACK) samp_d = sda_s;
        end else if (go_timeout) begin
          state_d  = ST_IDLE;
          done_d   = 1'b1;
          err_d    = ERR_TIMEOUT;
          rbit_d   = 1'b1;
          scl_oe_d = 1'b1;
          sda_oe_d = 1'b1;
        end
      end

      ST_HIGH: begin
        if (us_tick) begin
          ph_d = ph_q + HP_W'(1);
          if (is_recv && (ph_inc == mid_us)) samp_d = sda_s;
          if (op_q == OP_ACK)                samp_d = samp_q & sda_s;
          if (ph_last) begin
            state_d  = ST_LOW;
            scl_oe_d = 1'b0;
            ph_d     = '0;
            tclr     = 1'b1;
          end
        end
      end

      ST_LOW: begin
        if (us_tick) begin
          ph_d = ph_q + HP_W'(1);
          if (ph_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            rbit_d  = (op_q == OP_SEND) ? bit_q : samp_q;
            err_d   = ((op_q == OP_ACK) && samp_q) ? ERR_NACK : ERR_NONE;
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_SEND;
      bit_q    <= 1'b0;
      half_q   <= HP_W'(1);
      to_q     <= '0;
      scl_oe_q <= 1'b1;
      sda_oe_q <= 1'b1;
      ph_q     <= '0;
      wait_q   <= '0;
      pc_q     <= '0;
      samp_q   <= 1'b1;
      done_q   <= 1'b0;
      rbit_q   <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      if (accept) begin
        op_q   <= bit_op_e'(cmd_op);
        bit_q  <= cmd_bit;
        half_q <= half_calc;
        to_q   <= cfg_stretch_to_us;
      end
      state_q  <= state_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
      ph_q     <= ph_d;
      wait_q   <= wait_d;
      pc_q     <= pc_d;
      samp_q   <= samp_d;
      done_q   <= done_d;
      rbit_q   <= rbit_d;
      err_q    <= err_d;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_bit   = rbit_q;
  assign rsp_err   = err_q;
  assign scl_oe    = scl_oe_q;
  assign sda_oe    = sda_oe_q;

  // checks
  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == ST_LOW) |-> (half_q != '0)); // R2

  AST_SDA_BEFORE_SCL: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($rose(scl_oe_q) && (state_q == ST_WAIT)) |-> $stable(sda_oe_q)); // R3

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == ST_HIGH) |-> $stable(sda_oe_q)); // R3

  AST_SCL_FREE_HIGH: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == ST_HIGH) |-> scl_oe_q); // R4

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rsp_done && (rsp_err == ERR_TIMEOUT)) |-> (scl_oe && sda_oe)); // R5

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((state_q == ST_HIGH) && (op_q != OP_SEND)) |-> sda_oe_q); // R8

  AST_NACK_BIT: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rsp_done && (rsp_err == ERR_NACK)) |-> rsp_bit); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_done |=> !rsp_done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_done |-> cmd_ready); // R10

  AST_SCL_HELD: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rsp_done && (rsp_err != ERR_TIMEOUT)) |-> !scl_oe); // R11

endmodule

// File: tb/i2c_bit_engine_tb.sv
`timescale 1ns/1ps
module i2c_bit_engine_tb;

  localparam int P    = 4;
  localparam int FAST = 20;
  localparam int SLOW = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] cfg_khz = 10'd100;
  logic [7:0] cfg_lat = 8'd0;
  logic [19:0] cfg_to = 20'd1000;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_bit = 1'b0;
  logic       tgt_scl_low = 1'b0;
  logic       tgt_sda_low = 1'b0;

  wire        cmd_ready, rsp_done, rsp_bit, scl_oe, sda_oe;
  wire [1:0]  rsp_err;
  wire        scl_line = scl_oe & ~tgt_scl_low;
  wire        sda_line = sda_oe & ~tgt_sda_low;

  always #10 clk = ~clk;

  i2c_bit_engine #(
    .CLK_PER_US(P), .FAST_US(FAST), .SLOW_US(SLOW),
    .FREQ_W(10), .LAT_W(8), .TO_W(20), .HP_W(10)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_bus_khz(cfg_khz), .cfg_io_lat_us(cfg_lat), .cfg_stretch_to_us(cfg_to),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .rsp_done(rsp_done), .rsp_bit(rsp_bit), .rsp_err(rsp_err),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t_rise = 0, t_fall = 0, t_lhigh = 0, t_done = 0;
  int done_cnt = 0;
  logic got_bit = 1'b0;
  logic [1:0] got_err = 2'b00;
  logic sda_at_fall = 1'b1;
  logic prev_oe = 1'b1, prev_line = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (scl_oe && !prev_oe)     t_rise = cyc;
    if (!scl_oe && prev_oe) begin t_fall = cyc; sda_at_fall = sda_oe; end
    if (scl_line && !prev_line) t_lhigh = cyc;
    if (rsp_done) begin
      t_done   = cyc;
      got_bit  = rsp_bit;
      got_err  = rsp_err;
      done_cnt = done_cnt + 1;
    end
    prev_oe   = scl_oe;
    prev_line = scl_line;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic b);
    int n;
    n = done_cnt;
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
    chk("R10", "ready low while busy", int'(cmd_ready), 0);
    while (done_cnt == n) step();
    repeat (8) step();
    chk("R10", "one done per command", done_cnt, n + 1);
  endtask

  task automatic wait_line_high();
    while (!scl_line) step();
  endtask

  task automatic t_reset();
    chk("R1", "scl_oe after reset", int'(scl_oe), 1);
    chk("R1", "sda_oe after reset", int'(sda_oe), 1);
    chk("R1", "ready after reset", int'(cmd_ready), 1);
    chk("R1", "done after reset", int'(rsp_done), 0);
  endtask

  task automatic t_send(input logic b);
    run_cmd(2'b00, b);
    chk("R7", "send bit result", int'(got_bit), int'(b));
    chk("R7", "send err", int'(got_err), 0);
    chk("R3", "sda value through bit", int'(sda_at_fall), int'(b));
    chk("R11", "scl held low after bit", int'(scl_oe), 0);
  endtask

  task automatic t_half(input int khz, input int lat, input int h);
    cfg_khz = 10'(khz); cfg_lat = 8'(lat);
    run_cmd(2'b00, 1'b1);
    chk("R2", $sformatf("low phase %0dkHz lat %0d", khz, lat), t_done - t_fall, h * P);
    cfg_khz = 10'd100; cfg_lat = 8'd0;
  endtask

  task automatic t_recv_mid(input logic [1:0] op, input logic low_in_middle);
    tgt_sda_low = ~low_in_middle;
    fork
      run_cmd(op, 1'b0);
      begin
        wait_line_high();
        repeat (3 + 2 * P) step();
        tgt_sda_low = low_in_middle;
        repeat (2 * P) step();
        tgt_sda_low = 1'b0;
      end
    join
    chk("R8", "receive mid sample", int'(got_bit), low_in_middle ? 0 : 1);
    chk("R8", "receive err", int'(got_err), 0);
    chk("R4", "high time after line rise", t_fall - t_lhigh, 5 * P + 3);
  endtask

  task automatic t_ack(input logic pulse);
    fork
      run_cmd(2'b10, 1'b0);
      begin
        wait_line_high();
        repeat (3) step();
        tgt_sda_low = pulse;
        repeat (2 * P) step();
        tgt_sda_low = 1'b0;
      end
    join
    chk("R9", "ack bit", int'(got_bit), pulse ? 0 : 1);
    chk("R9", "ack err code", int'(got_err), pulse ? 0 : 2);
    chk("R9", "high phase not shortened", t_fall - t_lhigh, 5 * P + 3);
  endtask

  task automatic t_stretch_fast();
    tgt_scl_low = 1'b1;
    fork
      run_cmd(2'b00, 1'b0);
      begin
        while (!scl_oe) step();
        repeat (10 * P) step();
        tgt_scl_low = 1'b0;
      end
    join
    chk("R4", "high counted from line rise", t_fall - t_lhigh, 5 * P + 3);
    chk("R6", "fast poll result", int'(got_err), 0);
  endtask

  task automatic t_stretch_slow();
    tgt_scl_low = 1'b1;
    fork
      run_cmd(2'b00, 1'b1);
      begin
        while (!scl_oe) step();
        repeat (25 * P) step();
        tgt_scl_low = 1'b0;
      end
    join
    chk("R6", "slow poll instant", t_fall - t_rise, (FAST + SLOW) * P + 5 * P);
    chk("R6", "slow poll err", int'(got_err), 0);
  endtask

  task automatic t_timeout(input int lim, input int exp_cycles);
    cfg_to = 20'(lim);
    tgt_scl_low = 1'b1;
    run_cmd(2'b00, 1'b0);
    chk("R5", $sformatf("timeout err limit %0d", lim), int'(got_err), 1);
    chk("R5", $sformatf("timeout delay limit %0d", lim), t_done - t_rise, exp_cycles);
    chk("R5", "scl released after timeout", int'(scl_oe), 1);
    chk("R5", "sda released after timeout", int'(sda_oe), 1);
    tgt_scl_low = 1'b0;
    cfg_to = 20'd1000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    repeat (5) step();
    t_reset();
    t_send(1'b1);
    t_send(1'b0);
    t_half(100, 0, 5);
    t_half(100, 2, 3);
    t_half(400, 0, 1);
    t_half(100, 9, 1);
    t_half(0, 0, 500);
    t_recv_mid(2'b01, 1'b1);
    t_recv_mid(2'b01, 1'b0);
    t_recv_mid(2'b11, 1'b1);
    t_ack(1'b1);
    t_ack(1'b0);
    t_stretch_fast();
    t_stretch_slow();
    t_timeout(8, 8 * P + 1);
    repeat (4) step();
    t_send(1'b1);
    t_timeout(45, 50 * P);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule